// File: doc/BRIEF.md
# Selectable Even Clock Divider

This block takes one incoming clock and produces a slower clock whose period is an even multiple of the input period. A 3-bit select picks one of eight ratios, from 2 up to 16 in steps of 2. Every high phase and every low phase of the divided clock lasts exactly half the selected ratio, counted in input cycles, so the duty cycle is exactly 50%. A natural use is to distribute the clock at half rate and let storage downstream capture on both edges, which gives back the original update rate.

A synchronous stop input shuts the divided clock down cleanly. A high phase that is under way is always allowed to finish, and the output then parks low. After the stop is released, the divider runs a full-length low phase before its first rising edge. A new ratio on the select lines is only taken when a high phase begins, so no pulse is ever cut short. The enable output is high whenever the divider is running.

Top module: `even_clk_div`

## Requirements
- R1: The select code S (unsigned, 3 bits) sets the ratio N = 2*(S+1): code 0 gives divide-by-2 and code 7 gives divide-by-16. The first high phase after a start lasts S+1 input cycles.
- R2: While the select is steady and the stop is low, every high phase and every low phase lasts exactly S+1 input cycles.
- R3: `div_en_o` is high while the divider runs. While it is low, `div_clk_o` is also low.
- R4: When `srst_i` is sampled high while `div_clk_o` is low, the divider is idle after that edge: `div_en_o` is low and `div_clk_o` stays low for as long as `srst_i` remains high.
- R5: When `srst_i` is sampled high during a high phase, that high phase still lasts its full length. `div_clk_o` then falls, and `div_en_o` stays high until the next edge that sees `srst_i` with the output low.
- R6: On the first edge that samples `srst_i` low while idle, `div_en_o` rises with `div_clk_o` still low. `div_clk_o` rises S+1 cycles after that edge.
- R7: A change of select takes effect only at the next rising edge of `div_clk_o`. The phase in progress and the low phase before that rise keep the old length. The high phase that begins at that rise, and the low phase after it, use the new length.
- R8: No high or low phase is ever shorter than the length in force for it, including when a one-cycle stop pulse arrives during a low phase. In that case the low phase is stretched: it runs until the stop is released and then for a fresh S+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Incoming clock to be divided |
| srst_i | input | 1 | Synchronous stop/reset, active high |
| ratio_sel_i | input | 3 | Ratio code S, N = 2*(S+1) |
| div_clk_o | output | 1 | Divided clock, 50% duty cycle |
| div_en_o | output | 1 | High while the divider runs |

## Verification
The hardest cases to reach from the ports depend on the exact phase of the divided clock. One is a stop that lands partway through a high phase. Another is a select change that lands partway through a low phase. The stimulus reaches these by waiting on edges of `div_clk_o` itself and then driving the stop or select on the next falling input edge. This places each event at a known point inside a known phase, for every ratio. A scoreboard of expected phase lengths, built from the requirements, is compared against the measured length of every high and low phase, so a single truncated or stretched phase is caught.

// File: rtl/edc_pkg.sv
package edc_pkg;
   // Bit 1 = running, bit 0 = divided clock level (taken straight from a flop).
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_LOW  = 2'b10,
      ST_HIGH = 2'b11
   } phase_e;
endpackage

// File: rtl/edc_ratio_reg.sv
module edc_ratio_reg #(
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             load_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [SEL_W-1:0] lim_o
);
   // Holds (phase length - 1); equal to the select code by construction of the map.
   logic [SEL_W-1:0] lim_q;

   always_ff @(posedge clk_i) begin
      if (load_i) lim_q <= sel_i;
   end

   assign lim_o = lim_q;
endmodule

// File: rtl/edc_phase_cnt.sv
module edc_phase_cnt #(
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] lim_i,
   output logic             end_o
);
   logic [SEL_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) cnt_q <= '0;
      else       cnt_q <= cnt_q + SEL_W'(1);
   end

   assign end_o = (cnt_q == lim_i);

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (clr_i)
      cnt_q <= lim_i); // R2
endmodule

// File: rtl/edc_seq.sv
module edc_seq
   import edc_pkg::*;
(
   input  logic clk_i,
   input  logic srst_i,
   input  logic end_i,
   output logic clr_o,
   output logic load_o,
   output logic clk_lvl_o,
   output logic run_o
);
   phase_e st_q, st_d;

   always_comb begin
      st_d   = st_q;
      clr_o  = 1'b0;
      load_o = 1'b0;
      case (st_q)
         ST_IDLE: begin
            clr_o = 1'b1;
            if (!srst_i) begin
               st_d   = ST_LOW;
               load_o = 1'b1;
            end
         end
         ST_LOW: begin
            if (srst_i) begin
               st_d  = ST_IDLE;
               clr_o = 1'b1;
            end else if (end_i) begin
               st_d   = ST_HIGH;
               clr_o  = 1'b1;
               load_o = 1'b1;
            end
         end
         ST_HIGH: begin
            if (end_i) begin
               st_d  = ST_LOW;
               clr_o = 1'b1;
            end
         end
         default: begin
            st_d  = ST_IDLE;
            clr_o = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i) st_q <= st_d;

   assign clk_lvl_o = st_q[0];
   assign run_o     = st_q[1];

   AST_STOP_HOLDS_LOW: assert property (@(posedge clk_i)
      (srst_i && !clk_lvl_o) |=> !clk_lvl_o); // R4
   AST_STOP_GOES_IDLE: assert property (@(posedge clk_i)
      (srst_i && !clk_lvl_o) |=> !run_o); // R4
   AST_HIGH_NOT_CUT: assert property (@(posedge clk_i)
      (clk_lvl_o && !end_i) |=> clk_lvl_o); // R5
   AST_IDLE_IS_LOW: assert property (@(posedge clk_i)
      !run_o |-> !clk_lvl_o); // R3
endmodule

// File: rtl/even_clk_div.sv
module even_clk_div #(
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic [SEL_W-1:0] ratio_sel_i,
   output logic             div_clk_o,
   output logic             div_en_o
);
   localparam int HLW = SEL_W + 1;

   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel_w
         $error("even_clk_div: SEL_W must lie in 1..8");
      end
   endgenerate

   logic             clr_w, load_w, end_w;
   logic [SEL_W-1:0] lim_w;

   edc_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
      .clk_i (clk_i),
      .load_i(load_w),
      .sel_i (ratio_sel_i),
      .lim_o (lim_w)
   );

   edc_phase_cnt #(.SEL_W(SEL_W)) u_cnt (
      .clk_i(clk_i),
      .clr_i(clr_w),
      .lim_i(lim_w),
      .end_o(end_w)
   );

   edc_seq u_seq (
      .clk_i    (clk_i),
      .srst_i   (srst_i),
      .end_i    (end_w),
      .clr_o    (clr_w),
      .load_o   (load_w),
      .clk_lvl_o(div_clk_o),
      .run_o    (div_en_o)
   );

   // Checker-only measurement of each high phase.
   logic [HLW-1:0] hi_len_q;
   always_ff @(posedge clk_i) begin
      if (!div_clk_o) hi_len_q <= '0;
      else            hi_len_q <= hi_len_q + HLW'(1);
   end

   AST_HIGH_LEN: assert property (@(posedge clk_i)
      $fell(div_clk_o) |-> (hi_len_q == HLW'(lim_w) + HLW'(1))); // R2
   AST_RATIO_ONLY_AT_RISE: assert property (@(posedge clk_i) disable iff (srst_i)
      !$stable(lim_w) |-> ($rose(div_clk_o) || $rose(div_en_o))); // R7
endmodule

// File: tb/sim_even_clk_div.sv
`timescale 1ns/1ps
module sim_even_clk_div;
   logic       clk = 1'b0;
   logic       srst;
   logic [2:0] sel;
   logic       div_clk, div_en;

   int checks = 0;
   int failures = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   localparam int INF = 1 << 20;

   typedef struct {
      bit    lvl;
      int    lo;
      int    hi;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   even_clk_div #(.SEL_W(3)) u0 (
      .clk_i      (clk),
      .srst_i     (srst),
      .ratio_sel_i(sel),
      .div_clk_o  (div_clk),
      .div_en_o   (div_en)
   );

   task automatic push(input bit l, input int lo, input int hi, input string t);
      exp_t e;
      e.lvl = l; e.lo = lo; e.hi = hi; e.tag = t;
      exp_q.push_back(e);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Monitor: measures every phase of the divided clock and scores it.
   initial begin
      bit prev;
      int len;
      wait (mon_on);
      prev = div_clk;
      len  = 0;
      forever begin
         @(negedge clk);
         if (div_clk === prev) len++;
         else begin
            if (exp_q.size() == 0) begin
               checks++; failures++;
               $display("FAIL R8 unexpected phase level=%0d actual=%0d expected=none", prev, len);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.lvl == prev && len >= e.lo && len <= e.hi,
                     $sformatf("%s phase level=%0d", e.tag, e.lvl), len, e.lo);
            end
            prev = div_clk;
            len  = 1;
         end
      end
   end

   // Driver
   initial begin
      srst = 1'b1;
      sel  = '0;
      repeat (4) @(negedge clk);
      check(div_en == 1'b0, "R3 reset en", div_en, 0);
      check(div_clk == 1'b0, "R3 reset clk", div_clk, 0);
      mon_on = 1'b1;

      for (int s = 0; s < 8; s++) begin
         int h;
         h = s + 1;
         push(1'b0, h, INF, "R6");
         push(1'b1, h, h, "R1");
         push(1'b0, h, h, "R2");
         push(1'b1, h, h, "R2");
         push(1'b0, h, h, "R2");
         push(1'b1, h, h, "R5");
         @(negedge clk);
         sel  = 3'(s);
         srst = 1'b0;
         @(negedge clk);
         check(div_en == 1'b1, "R3 en after start", div_en, 1);
         check(div_clk == 1'b0, "R6 clk low at start", div_clk, 0);
         repeat (3) @(posedge div_clk);
         @(negedge clk);
         srst = 1'b1;
         repeat (h) @(negedge clk);
         check(div_clk == 1'b0, "R5 high phase ended", div_clk, 0);
         check(div_en == 1'b1, "R5 en kept through fall", div_en, 1);
         @(negedge clk);
         check(div_en == 1'b0, "R4 idle en", div_en, 0);
         check(div_clk == 1'b0, "R4 idle clk", div_clk, 0);
         repeat (4) @(negedge clk);
         check(div_clk == 1'b0 && div_en == 1'b0, "R4 held idle", div_clk, 0);
      end

      // Ratio change in a high phase and then in a low phase
      push(1'b0, 3, INF, "R6");
      push(1'b1, 3, 3, "R7");
      push(1'b0, 3, 3, "R7");
      push(1'b1, 7, 7, "R7");
      push(1'b0, 7, 7, "R7");
      push(1'b1, 7, 7, "R7");
      push(1'b0, 7, 7, "R7");
      push(1'b1, 1, 1, "R7");
      @(negedge clk);
      sel  = 3'd2;
      srst = 1'b0;
      @(posedge div_clk);
      @(negedge clk);
      sel = 3'd6;
      repeat (3) @(negedge div_clk);
      @(negedge clk);
      sel = 3'd0;
      @(posedge div_clk);
      @(negedge clk);
      srst = 1'b1;
      repeat (6) @(negedge clk);

      // One-cycle stop pulse inside a low phase
      push(1'b0, 4, INF, "R6");
      push(1'b1, 4, 4, "R2");
      push(1'b0, 6, 6, "R8");
      push(1'b1, 4, 4, "R8");
      push(1'b0, 4, 4, "R8");
      push(1'b1, 4, 4, "R8");
      @(negedge clk);
      sel  = 3'd3;
      srst = 1'b0;
      @(negedge div_clk);
      @(negedge clk);
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      repeat (2) @(posedge div_clk);
      @(negedge clk);
      srst = 1'b1;
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R8 all phases seen", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule